// File: doc/BRIEF.md
# Host Interrupt Request Generator

This block raises level interrupt request lines toward an external host for a host interface with three data channels and one extra two-way register bank. The local processor controls it over a small register bus. It writes the output data registers of the channels (only the write event matters here), sets and clears per-line enable bits, and selects a per-channel mode. The host side gives one read-strobe pulse each time it reads one of the data registers.

In data-dependent mode, firmware first writes a data register. It then reads the enable bit, sees 0 and writes it to 1. That 0-to-1 write raises the request only if the data register has been written since the host last read it. The request drops when the host reads that register or when firmware writes the enable to 0. In direct mode, the 0-to-1 write alone raises the request, and only a 0 write removes it. The seven outputs (IRQ1, IRQ12, IRQ6, IRQ9, IRQ10, IRQ11 and SMI) each merge every source that drives that line.

Top module: `hirq_gen`

## Requirements
- R1: While reset is active and directly after it, every request output is 0. Reading the three control registers at addresses 4, 5 and 6 returns 0.
- R2: In data-dependent mode, a write of 1 to an enable bit that currently reads 0 raises its request one clock later, provided its data register was written since the last host read of that register. Data registers sit at address 0 (channel 1), 1 (channel 2), 2 (channel 3) and 3 (last bank register). Channel 1 enables are at address 4, bit 0 for IRQ1 and bit 1 for IRQ12.
- R3: Writing 0 to an enable bit drops its request one clock later, in either mode.
- R4: In data-dependent mode, a host read strobe for the paired data register drops the request one clock later, and the enable bit keeps reading 1. Host strobe bits 0 to 3 map to data registers 0 to 3. A host read in the same cycle as a setting write wins.
- R5: A 0-to-1 enable write raises nothing when its own data register has no pending write. This covers a register that was never written, one already read by the host, and the case where only another channel's register was written.
- R6: Channel 2's control register is at address 5, with bit 0 for SMI, bits 1 to 4 for IRQ6, IRQ9, IRQ10 and IRQ11, and bit 7 for the mode (1 = direct). In direct mode, a 0-to-1 enable write raises the request with no data write, and host reads leave it set. A mode value written in the same write as the enable already applies to that enable.
- R7: Channel 3's control register is at address 6, with bit 0 for SMI A, bit 1 for SMI B, bits 2 to 5 for IRQ6, IRQ9, IRQ10 and IRQ11, and bit 7 for its own mode. SMI B is paired with data register 3 and the other channel 3 sources with data register 2.
- R8: SMI is the OR of channel 2 SMI and both channel 3 SMI sources. Each of IRQ6, IRQ9, IRQ10 and IRQ11 is the OR of its channel 2 and channel 3 sources. A line stays high while any of its sources remains.
- R9: Reading the control registers returns the stored enable and mode bits at the positions given above. Unused bits read as 0.
- R10: Writing 1 to an enable bit that already reads 1 raises no request, even when a data write is pending.
- R11: Request outputs change only on the clock after a bus write or a host read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe from local processor |
| bus_addr | input | ADDR_W | Register address for write and read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed control register (combinational) |
| host_rd | input | 4 | One-cycle host read strobes for data registers 0 to 3 |
| irq1_o | output | 1 | IRQ1 request, active high |
| irq12_o | output | 1 | IRQ12 request, active high |
| irq6_o | output | 1 | IRQ6 request, active high |
| irq9_o | output | 1 | IRQ9 request, active high |
| irq10_o | output | 1 | IRQ10 request, active high |
| irq11_o | output | 1 | IRQ11 request, active high |
| smi_o | output | 1 | SMI request, active high |

## Verification
The properties assume that host read strobes last one clock and that the bus makes at most one access per clock. They also assume that nothing toggles the bus inputs during reset release, so a rise on a line can always be traced back to the previous cycle's write. The stimulus performs a single write or a single host strobe per step, with idle cycles in between, and waits several idle clocks after reset before the first access. A behavioural model in the bench tracks enables, modes and pending-write flags for every source and is compared with all seven outputs on each step.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

  localparam int NSRC  = 13;
  localparam int NDR   = 4;
  localparam int NLINE = 7;
  localparam int NCHM  = 2;

  localparam int A_CH1 = 4;
  localparam int A_CH2 = 5;
  localparam int A_CH3 = 6;

  typedef enum int {
    LN_IRQ1  = 0,
    LN_IRQ12 = 1,
    LN_IRQ6  = 2,
    LN_IRQ9  = 3,
    LN_IRQ10 = 4,
    LN_IRQ11 = 5,
    LN_SMI   = 6
  } line_e;

  // Source order: 0..1 channel 1, 2..6 channel 2, 7..12 channel 3
  function automatic int src_chan(input int s);
    if (s < 2)      return 0;
    else if (s < 7) return 1;
    else            return 2;
  endfunction

  function automatic int src_reg(input int s);
    return A_CH1 + src_chan(s);
  endfunction

  function automatic int src_bit(input int s);
    if (s < 2)      return s;
    else if (s < 7) return s - 2;
    else            return s - 7;
  endfunction

  function automatic int src_dr(input int s);
    if (s < 2)       return 0;
    else if (s < 7)  return 1;
    else if (s == 8) return 3;
    else             return 2;
  endfunction

  function automatic int src_line(input int s);
    if (s == 0)                      return LN_IRQ1;
    else if (s == 1)                 return LN_IRQ12;
    else if (s == 2 || s == 7 || s == 8) return LN_SMI;
    else if (s < 7)                  return LN_IRQ6 + (s - 3);
    else                             return LN_IRQ6 + (s - 9);
  endfunction

endpackage

// File: rtl/hirq_bus_regs.sv
module hirq_bus_regs
  import hirq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int MODE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   en_hit,
  output logic [NSRC-1:0]   en_wbit,
  output logic [NCHM-1:0]   mode_q,
  output logic [NCHM-1:0]   mode_eff
);

  logic [NSRC-1:0] en_d;
  logic [NSRC-1:0] en_ce;
  logic [NCHM-1:0] mode_d;
  logic [NCHM-1:0] mode_ce;
  logic            unused_wdata_bits;

  assign unused_wdata_bits = ^wdata;

  for (genvar s = 0; s < NSRC; s++) begin : g_en
    localparam int RA = src_reg(s);
    localparam int RB = src_bit(s);

    assign en_hit[s]  = wr && (addr == ADDR_W'(RA));
    assign en_wbit[s] = wdata[RB];

    always_comb begin
      en_ce[s] = en_hit[s];
      en_d[s]  = en_wbit[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q[s] <= 1'b0;
      else if (en_ce[s]) en_q[s] <= en_d[s];
    end
  end

  for (genvar c = 0; c < NCHM; c++) begin : g_mode
    localparam int MA = A_CH2 + c;

    always_comb begin
      mode_ce[c]  = wr && (addr == ADDR_W'(MA));
      mode_d[c]   = wdata[MODE_BIT];
      mode_eff[c] = mode_ce[c] ? mode_d[c] : mode_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mode_q[c] <= 1'b0;
      else if (mode_ce[c]) mode_q[c] <= mode_d[c];
    end
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (addr == ADDR_W'(src_reg(s))) rdata[src_bit(s)] = en_q[s];
    end
    for (int c = 0; c < NCHM; c++) begin
      if (addr == ADDR_W'(A_CH2 + c)) rdata[MODE_BIT] = mode_q[c];
    end
  end

endmodule

// File: rtl/hirq_data_flags.sv
module hirq_data_flags #(
  parameter int ADDR_W = 4,
  parameter int N_DR   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_DR-1:0]   host_rd,
  output logic [N_DR-1:0]   flag_q
);

  logic [N_DR-1:0] flag_d;
  logic [N_DR-1:0] flag_ce;
  logic [N_DR-1:0] wr_hit;

  for (genvar d = 0; d < N_DR; d++) begin : g_flag
    always_comb begin
      wr_hit[d]  = wr && (addr == ADDR_W'(d));
      flag_ce[d] = wr_hit[d] || host_rd[d];
      flag_d[d]  = wr_hit[d];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[d] <= 1'b0;
      else if (flag_ce[d]) flag_q[d] <= flag_d[d];
    end
  end

endmodule

// File: rtl/hirq_source.sv
module hirq_source (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_hit,
  input  logic en_wbit,
  input  logic direct_set,
  input  logic direct_q,
  input  logic flag,
  input  logic host_rd,
  output logic req_d,
  output logic req_q
);

  logic rise;
  logic set;
  logic clr;
  logic req_ce;

  always_comb begin
    rise   = en_hit && en_wbit && !en_q;
    set    = rise && (direct_set || flag);
    clr    = (en_hit && !en_wbit) || (host_rd && !direct_q);
    req_ce = set || clr;
    req_d  = clr ? 1'b0 : (set ? 1'b1 : req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (req_ce) req_q <= req_d;
  end

endmodule

// File: rtl/hirq_line_merge.sv
module hirq_line_merge
  import hirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_d,
  output logic [NLINE-1:0] line_q
);

  logic [NLINE-1:0] line_d;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    always_comb begin
      line_d[l] = 1'b0;
      for (int s = 0; s < NSRC; s++) begin
        if (src_line(s) == l) line_d[l] = line_d[l] | req_d[s];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[l] <= 1'b0;
      else        line_q[l] <= line_d[l];
    end
  end

endmodule

// File: rtl/hirq_gen.sv
module hirq_gen
  import hirq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int MODE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NDR-1:0]    host_rd,
  output logic              irq1_o,
  output logic              irq12_o,
  output logic              irq6_o,
  output logic              irq9_o,
  output logic              irq10_o,
  output logic              irq11_o,
  output logic              smi_o
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [NSRC-1:0]  en_q;
  logic [NSRC-1:0]  en_hit;
  logic [NSRC-1:0]  en_wbit;
  logic [NCHM-1:0]  mode_q;
  logic [NCHM-1:0]  mode_eff;
  logic [NDR-1:0]   flag_q;
  logic [NSRC-1:0]  req_d;
  logic [NSRC-1:0]  req_q;
  logic [NLINE-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  hirq_bus_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MODE_BIT(MODE_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .en_q    (en_q),
    .en_hit  (en_hit),
    .en_wbit (en_wbit),
    .mode_q  (mode_q),
    .mode_eff(mode_eff)
  );

  hirq_data_flags #(
    .ADDR_W(ADDR_W),
    .N_DR  (NDR)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .host_rd(host_rd),
    .flag_q (flag_q)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int CH = src_chan(s);
    localparam int DR = src_dr(s);
    logic dset;
    logic dq;

    if (CH == 0) begin : g_fixed
      assign dset = 1'b0;
      assign dq   = 1'b0;
    end else begin : g_moded
      assign dset = mode_eff[CH-1];
      assign dq   = mode_q[CH-1];
    end

    hirq_source u_src (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .en_q      (en_q[s]),
      .en_hit    (en_hit[s]),
      .en_wbit   (en_wbit[s]),
      .direct_set(dset),
      .direct_q  (dq),
      .flag      (flag_q[DR]),
      .host_rd   (host_rd[DR]),
      .req_d     (req_d[s]),
      .req_q     (req_q[s])
    );
  end

  hirq_line_merge u_merge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req_d (req_d),
    .line_q(line_q)
  );

  logic unused_req_state;
  assign unused_req_state = ^req_q;

  assign irq1_o  = line_q[LN_IRQ1];
  assign irq12_o = line_q[LN_IRQ12];
  assign irq6_o  = line_q[LN_IRQ6];
  assign irq9_o  = line_q[LN_IRQ9];
  assign irq10_o = line_q[LN_IRQ10];
  assign irq11_o = line_q[LN_IRQ11];
  assign smi_o   = line_q[LN_SMI];

endmodule

// File: rtl/hirq_gen_chk.sv
module hirq_gen_chk
  import hirq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NDR-1:0]    host_rd,
  input logic              irq1_o,
  input logic              irq12_o,
  input logic              irq6_o,
  input logic              irq9_o,
  input logic              irq10_o,
  input logic              irq11_o,
  input logic              smi_o
);

  logic [NLINE-1:0] lines;
  assign lines = {smi_o, irq11_o, irq10_o, irq9_o, irq6_o, irq12_o, irq1_o};

  assert_irq1_off_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == ADDR_W'(A_CH1) && !bus_wdata[0]) |=> !irq1_o);

  assert_host_clear_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_rd[0] |=> (!irq1_o && !irq12_o));

  assert_irq1_cause_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq1_o) |-> $past(bus_wr && bus_addr == ADDR_W'(A_CH1) && bus_wdata[0]));

  assert_smi_cause_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(smi_o) |-> $past(bus_wr && (bus_addr == ADDR_W'(A_CH2) || bus_addr == ADDR_W'(A_CH3))));

  assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_wr && host_rd == '0) |=> $stable(lines));

endmodule

bind hirq_gen hirq_gen_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .host_rd   (host_rd),
  .irq1_o    (irq1_o),
  .irq12_o   (irq12_o),
  .irq6_o    (irq6_o),
  .irq9_o    (irq9_o),
  .irq10_o   (irq10_o),
  .irq11_o   (irq11_o),
  .smi_o     (smi_o)
);

// File: tb/hirq_gen_test.sv
module hirq_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [3:0] host_rd = 4'd0;
  logic       irq1_o, irq12_o, irq6_o, irq9_o, irq10_o, irq11_o, smi_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit m_en[13];
  bit m_req[13];
  bit m_flag[4];
  bit m_mode[2];
  int t_reg[13]  = '{4, 4, 5, 5, 5, 5, 5, 6, 6, 6, 6, 6, 6};
  int t_bit[13]  = '{0, 1, 0, 1, 2, 3, 4, 0, 1, 2, 3, 4, 5};
  int t_chan[13] = '{0, 0, 1, 1, 1, 1, 1, 2, 2, 2, 2, 2, 2};
  int t_dr[13]   = '{0, 0, 1, 1, 1, 1, 1, 2, 3, 2, 2, 2, 2};

  always #5 clk = ~clk;

  hirq_gen uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_rd(host_rd),
    .irq1_o(irq1_o), .irq12_o(irq12_o), .irq6_o(irq6_o), .irq9_o(irq9_o),
    .irq10_o(irq10_o), .irq11_o(irq11_o), .smi_o(smi_o)
  );

  function automatic logic [6:0] model_lines();
    logic [6:0] v;
    v[0] = m_req[0];
    v[1] = m_req[1];
    v[2] = m_req[3] | m_req[9];
    v[3] = m_req[4] | m_req[10];
    v[4] = m_req[5] | m_req[11];
    v[5] = m_req[6] | m_req[12];
    v[6] = m_req[2] | m_req[7] | m_req[8];
    return v;
  endfunction

  function automatic logic [7:0] model_read(input int a);
    logic [7:0] v = 8'd0;
    for (int s = 0; s < 13; s++) if (t_reg[s] == a) v[t_bit[s]] = m_en[s];
    if (a == 5) v[7] = m_mode[0];
    if (a == 6) v[7] = m_mode[1];
    return v;
  endfunction

  task automatic model_update(input logic w, input int a, input logic [7:0] d, input logic [3:0] h);
    bit n_en[13];
    bit n_req[13];
    for (int s = 0; s < 13; s++) begin
      bit hit, wb, mnew, mold;
      hit = w && (a == t_reg[s]);
      wb = d[t_bit[s]];
      mold = (t_chan[s] == 0) ? 1'b0 : m_mode[t_chan[s]-1];
      mnew = (t_chan[s] != 0 && w && a == 4 + t_chan[s]) ? d[7] : mold;
      n_req[s] = m_req[s];
      if (hit && !wb) n_req[s] = 1'b0;
      else if (h[t_dr[s]] && !mold) n_req[s] = 1'b0;
      else if (hit && wb && !m_en[s] && (mnew || m_flag[t_dr[s]])) n_req[s] = 1'b1;
      n_en[s] = hit ? wb : m_en[s];
    end
    for (int s = 0; s < 13; s++) begin
      m_en[s] = n_en[s];
      m_req[s] = n_req[s];
    end
    for (int k = 0; k < 4; k++) begin
      if (w && a == k) m_flag[k] = 1'b1;
      else if (h[k]) m_flag[k] = 1'b0;
    end
    if (w && a == 5) m_mode[0] = d[7];
    if (w && a == 6) m_mode[1] = d[7];
  endtask

  task automatic compare_lines(input string tag);
    logic [6:0] got, exp;
    got = {smi_o, irq11_o, irq10_o, irq9_o, irq6_o, irq12_o, irq1_o};
    exp = model_lines();
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s lines actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic w, input int a, input logic [7:0] d, input logic [3:0] h, input string tag);
    @(negedge clk);
    bus_wr = w; bus_addr = 4'(a); bus_wdata = d; host_rd = h;
    model_update(w, a, d, h);
    @(posedge clk);
    #2;
    compare_lines(tag);
  endtask

  task automatic wr(input int a, input logic [7:0] d, input string tag);
    step(1'b1, a, d, 4'd0, tag);
  endtask

  task automatic hread(input logic [3:0] h, input string tag);
    step(1'b0, 0, 8'd0, h, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 8'd0, 4'd0, tag);
  endtask

  task automatic rd_check(input int a, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    bus_wr = 1'b0; host_rd = 4'd0; bus_addr = 4'(a);
    #1;
    exp = model_read(a);
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s readback addr %0d actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int s = 0; s < 13; s++) begin m_en[s] = 0; m_req[s] = 0; end
    for (int k = 0; k < 4; k++) m_flag[k] = 0;
    m_mode[0] = 0; m_mode[1] = 0;

    repeat (3) @(posedge clk);
    #2 compare_lines("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    idle(4, "R1 after reset");
    rd_check(4, "R1"); rd_check(5, "R1"); rd_check(6, "R1");

    // channel 1, no data written
    wr(4, 8'h01, "R5 no data write");
    wr(4, 8'h00, "R3");
    // channel 1 data-dependent set
    wr(0, 8'h5A, "R2 data write");
    wr(4, 8'h01, "R2 irq1 set");
    wr(4, 8'h03, "R2 irq12 set");
    wr(4, 8'h03, "R10 rewrite one");
    idle(2, "R11 hold");
    hread(4'b0001, "R4 host read clears");
    rd_check(4, "R4 enables kept");
    wr(4, 8'h03, "R10 no reset after read");
    wr(4, 8'h00, "R3");
    wr(4, 8'h01, "R5 flag consumed");
    wr(0, 8'h11, "R2");
    wr(4, 8'h00, "R3");
    wr(4, 8'h01, "R2 reset by 0 then 1");
    wr(4, 8'h00, "R3 clear by zero");
    // other channel's data does not help channel 1
    wr(1, 8'h22, "R5 channel 2 data");
    wr(4, 8'h01, "R5 cross channel");
    wr(4, 8'h00, "R3");
    // channel 2 data-dependent
    wr(5, 8'h01, "R2 channel 2 smi");
    wr(5, 8'h03, "R2 channel 2 irq6");
    hread(4'b0010, "R4 channel 2 host read");
    wr(5, 8'h00, "R3");
    // channel 2 direct
    wr(5, 8'h80, "R6 mode on");
    wr(5, 8'h81, "R6 direct set");
    hread(4'b0010, "R6 host read ignored");
    idle(1, "R6 still set");
    wr(5, 8'h80, "R3 direct clear");
    wr(5, 8'h00, "R6 mode off");
    wr(5, 8'h84, "R6 mode in same write");
    wr(5, 8'h80, "R3");
    // channel 3
    wr(3, 8'h33, "R7 bank write");
    wr(6, 8'h02, "R7 smi b set");
    wr(6, 8'h01, "R7 smi a needs reg 2");
    wr(2, 8'h44, "R7 reg 2 write");
    wr(6, 8'h00, "R3");
    wr(6, 8'h03, "R7 both smi set");
    hread(4'b1000, "R8 smi held by a");
    hread(4'b0100, "R8 smi drops");
    // channel 3 independent of channel 2 mode
    wr(6, 8'h00, "R3");
    wr(6, 8'h04, "R7 ch3 data mode while ch2 direct");
    // line merge on irq6
    wr(5, 8'h82, "R8 ch2 irq6");
    wr(2, 8'h55, "R8 reg 2 write");
    wr(6, 8'h04, "R10 already enabled");
    wr(6, 8'h00, "R3");
    wr(6, 8'h04, "R8 ch3 irq6");
    wr(5, 8'h80, "R8 irq6 held by ch3");
    hread(4'b0100, "R8 irq6 drops");
    // channel 3 direct, all irq lines
    wr(6, 8'hBC, "R7 ch3 direct irqs");
    hread(4'b0100, "R7 direct ignores read");
    rd_check(6, "R9 ch3 readback");
    wr(5, 8'hFF, "R8 ch2 all");
    rd_check(5, "R9 ch2 readback");
    wr(4, 8'hFF, "R9 ch1 write");
    rd_check(4, "R9 ch1 readback");
    rd_check(2, "R9 data address reads zero");
    wr(6, 8'h80, "R8 ch2 holds lines");
    wr(5, 8'h00, "R3 all off");
    wr(4, 8'h00, "R3");
    idle(3, "R11 quiet");
    finish_up();
  end

endmodule